// File: doc/BRIEF.md
# PRBS Test-Mode Register Configuration Sequencer

This controller switches a serial link's pseudo-random test pattern on by editing a short, fixed list of configuration registers through a memory-mapped reconfiguration port. A single start pulse selects the transmit side, the receive side or both. The pulse also carries the polynomial choice and the two inversion settings. The block then visits each register it owns in a fixed order.

Each register is edited in place. The sequencer reads the register and waits for its data. It replaces only the bit fields it is responsible for and writes the merged word back. Every other bit of the register, including all bits above the low byte, keeps its value. Only one bus transaction is in flight at any time. The host only needs to watch `busy` and the one-cycle `donePulse`.

Top module: `tcs_seq`

## Requirements
- R1: After reset, `busy`, `donePulse`, `busRead` and `busWrite` are all low, and while `busy` is low the bus stays idle.
- R2: Every register is updated by a read, then a merge, then a write to the same address. Bits outside the owned fields keep the value just read, and this includes every bit above bit 7.
- R3: The transmit side writes offsets 0x6, 0x7 and 0x8 in that order. At 0x6 the merge sets bits [2:0] to 3'b100, bit 3 to 0 and bits [7:6] to 2'b01.
- R4: At 0x7, bit 2 takes `txInvSel`. The 2-bit `polySel` (0 = PRBS9, 1 = PRBS15, 2 = PRBS23, 3 = PRBS31) sets exactly one enable to 1 and clears the other three. Those enables are 0x7 bit 5, 0x7 bit 6, 0x7 bit 7 and 0x8 bit 4 respectively.
- R5: The receive side writes offset 0xA. Its bit 4 takes `rxInvSel` and its bit 7 is set to 1.
- R6: `sideSel` bit 0 enables the transmit list and bit 1 enables the receive list. With both set, all transmit writes complete before the receive read starts. A start with `sideSel` = 0 does nothing.
- R7: A read is held with a stable address while `waitrequest` is high. No write is issued before `readdatavalid` has returned the data. A write is held with stable address and data while `waitrequest` is high. Read and write are never high together.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle after the last write is accepted. `donePulse` is high for exactly that one cycle. A start seen while `busy` is high is ignored.
- R9: The side, polynomial and invert inputs are sampled on the accepted start. Changes to them while `busy` is high have no effect on the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a configuration pass |
| sideSel | input | 2 | Bit 0 selects transmit, bit 1 selects receive |
| polySel | input | 2 | Polynomial choice: 0 PRBS9, 1 PRBS15, 2 PRBS23, 3 PRBS31 |
| txInvSel | input | 1 | Value written to the transmit invert control bit |
| rxInvSel | input | 1 | Value written to the receive expect-invert control bit |
| busy | output | 1 | Pass in progress |
| donePulse | output | 1 | One-cycle completion strobe |
| busAddr | output | ADDR_W | Register offset on the reconfiguration port |
| busRead | output | 1 | Read request |
| busWrite | output | 1 | Write request |
| busWdata | output | DATA_W | Merged write data |
| busRdata | input | DATA_W | Read data |
| busRdValid | input | 1 | Read data valid |
| busWaitReq | input | 1 | Slave stall; request held while high |

## Verification
The bench builds the block with ADDR_W = 12 and DATA_W = 32. With these widths, the 24 bits above the owned byte are exercised for preservation. An address that is wider than the offsets shows any stray upper address bits. The slave model returns data two cycles after a read is accepted and can insert pseudo-random wait states. It is preloaded with a mixed pattern, then all ones, then all zeros, so every owned field has to move in both directions. The bench covers all four polynomial codes, both invert values, each side selection, and a restart plus input changes in the middle of a pass.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int NUM_ENTRIES = 4;
  localparam int IDX_W       = 2;
  localparam int FIELD_W     = 8;
  localparam int LAST_TX_IDX = 2;
  localparam int RX_IDX      = 3;
  localparam int POLY_N      = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_READ,
    SEQ_WAIT,
    SEQ_WRITE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic captureRd;
    logic nextEntry;
  } seqStrobe_t;

  // register offset of each list entry; order is the update order
  function automatic logic [FIELD_W-1:0] entryOffset(input int i);
    case (i)
      0:       return 8'h06;
      1:       return 8'h07;
      2:       return 8'h08;
      default: return 8'h0A;
    endcase
  endfunction

  // owned bits of each entry
  function automatic logic [FIELD_W-1:0] entryMask(input int i);
    case (i)
      0:       return 8'hCF;
      1:       return 8'hE4;
      2:       return 8'h10;
      default: return 8'h90;
    endcase
  endfunction

  // value placed into the owned bits
  function automatic logic [FIELD_W-1:0] entryValue(input int i,
                                                    input logic [POLY_N-1:0] polyHot,
                                                    input logic txInv,
                                                    input logic rxInv);
    case (i)
      0:       return 8'h44;
      1:       return {polyHot[2], polyHot[1], polyHot[0], 2'b00, txInv, 2'b00};
      2:       return {3'b000, polyHot[3], 4'b0000};
      default: return {1'b1, 2'b00, rxInv, 4'b0000};
    endcase
  endfunction

endpackage

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [1:0] sideSel,
  input  logic       isLast,
  input  logic       busWaitReq,
  input  logic       busRdValid,
  output seqStrobe_t strobe,
  output logic       busRead,
  output logic       busWrite,
  output logic       busy,
  output logic       donePulse
);

  seqState_t state;
  seqState_t nextState;
  logic      doneNext;

  always_comb begin
    nextState = state;
    strobe    = '0;
    doneNext  = 1'b0;
    busRead   = 1'b0;
    busWrite  = 1'b0;
    case (state)
      SEQ_IDLE: begin
        if (startPulse && (sideSel != 2'b00)) begin
          strobe.loadCfg = 1'b1;
          nextState      = SEQ_READ;
        end
      end
      SEQ_READ: begin
        busRead = 1'b1;
        if (!busWaitReq) nextState = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (busRdValid) begin
          strobe.captureRd = 1'b1;
          nextState        = SEQ_WRITE;
        end
      end
      SEQ_WRITE: begin
        busWrite = 1'b1;
        if (!busWaitReq) begin
          if (isLast) begin
            nextState = SEQ_IDLE;
            doneNext  = 1'b1;
          end else begin
            strobe.nextEntry = 1'b1;
            nextState        = SEQ_READ;
          end
        end
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      donePulse <= 1'b0;
    end else begin
      state     <= nextState;
      donePulse <= doneNext;
    end
  end

  assign busy = (state != SEQ_IDLE);

endmodule

// File: rtl/tcs_dpath.sv
module tcs_dpath
  import tcs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [1:0]        sideSel,
  input  logic [1:0]        polySel,
  input  logic              txInvSel,
  input  logic              rxInvSel,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              isLast
);

  localparam logic [IDX_W-1:0] RX_SLOT   = IDX_W'(RX_IDX);
  localparam logic [IDX_W-1:0] TX_LAST   = IDX_W'(LAST_TX_IDX);
  localparam int               UPPER_W   = DATA_W - FIELD_W;

  logic [IDX_W-1:0]  idx;
  logic              rxOn;
  logic [POLY_N-1:0] polyHot;
  logic              txInv;
  logic              rxInv;
  logic [DATA_W-1:0] rdHold;

  logic [FIELD_W-1:0] entOfs  [NUM_ENTRIES];
  logic [FIELD_W-1:0] entMask [NUM_ENTRIES];
  logic [FIELD_W-1:0] entVal  [NUM_ENTRIES];
  logic [FIELD_W-1:0] mergedLow;

  // settings are frozen at the accepted start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= '0;
      rxOn    <= 1'b0;
      polyHot <= '0;
      txInv   <= 1'b0;
      rxInv   <= 1'b0;
    end else if (strobe.loadCfg) begin
      rxOn    <= sideSel[1];
      polyHot <= POLY_N'(1) << polySel;
      txInv   <= txInvSel;
      rxInv   <= rxInvSel;
      idx     <= sideSel[0] ? '0 : RX_SLOT;
    end else if (strobe.nextEntry) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHold <= '0;
    end else if (strobe.captureRd) begin
      rdHold <= busRdata;
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    assign entOfs[g]  = entryOffset(g);
    assign entMask[g] = entryMask(g);
    assign entVal[g]  = entryValue(g, polyHot, txInv, rxInv);
  end

  always_comb begin
    mergedLow = (rdHold[FIELD_W-1:0] & ~entMask[idx]) | (entVal[idx] & entMask[idx]);
  end

  if (UPPER_W > 0) begin : g_upper
    assign busWdata = {rdHold[DATA_W-1:FIELD_W], mergedLow};
  end else begin : g_noupper
    assign busWdata = mergedLow[DATA_W-1:0];
  end

  assign busAddr = ADDR_W'(entOfs[idx]);
  assign isLast  = (idx == RX_SLOT) || ((idx == TX_LAST) && !rxOn);

endmodule

// File: rtl/tcs_seq.sv
module tcs_seq
  import tcs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [1:0]        sideSel,
  input  logic [1:0]        polySel,
  input  logic              txInvSel,
  input  logic              rxInvSel,
  output logic              busy,
  output logic              donePulse,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRead,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busRdValid,
  input  logic              busWaitReq
);

  seqStrobe_t strobe;
  logic       isLast;

  tcs_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .sideSel    (sideSel),
    .isLast     (isLast),
    .busWaitReq (busWaitReq),
    .busRdValid (busRdValid),
    .strobe     (strobe),
    .busRead    (busRead),
    .busWrite   (busWrite),
    .busy       (busy),
    .donePulse  (donePulse)
  );

  tcs_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sideSel  (sideSel),
    .polySel  (polySel),
    .txInvSel (txInvSel),
    .rxInvSel (rxInvSel),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .isLast   (isLast)
  );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              donePulse,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRead,
  input logic              busWrite,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-9:0] rdUpper,
  input logic              busRdValid,
  input logic              busWaitReq
);

  logic [DATA_W-9:0] upperSeen;
  logic              haveData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperSeen <= '0;
      haveData  <= 1'b0;
    end else if (busRdValid) begin
      upperSeen <= rdUpper;
      haveData  <= 1'b1;
    end else if (busWrite && !busWaitReq) begin
      haveData <= 1'b0;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busRead && !busWrite));

  a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> (busWdata[DATA_W-1:8] == upperSeen));

  a_r3_first_fields: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(6)) |-> (busWdata[7:6] == 2'b01 && busWdata[3:0] == 4'b0100));

  a_r4_poly_atmost_one: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(7)) |-> ($countones(busWdata[7:5]) <= 1));

  a_r5_rx_clock_on: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(10)) |-> busWdata[7]);

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite));

  a_r7_write_after_data: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> haveData);

  a_r7_read_held: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busWaitReq) |=> (busRead && $stable(busAddr)));

  a_r7_write_held: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busWaitReq) |=> (busWrite && $stable(busAddr) && $stable(busWdata)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && $past(busy)));

endmodule

bind tcs_seq tcs_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .donePulse  (donePulse),
  .busAddr    (busAddr),
  .busRead    (busRead),
  .busWrite   (busWrite),
  .busWdata   (busWdata),
  .rdUpper    (busRdata[DATA_W-1:8]),
  .busRdValid (busRdValid),
  .busWaitReq (busWaitReq)
);

// File: tb/tcs_seq_tb_top.sv
module tcs_seq_tb_top;

  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int MEM_DEPTH = 16;
  localparam int RD_LAT    = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic [1:0]        sideSel = 2'b00;
  logic [1:0]        polySel = 2'b00;
  logic              txInvSel = 1'b0;
  logic              rxInvSel = 1'b0;
  logic              busy;
  logic              donePulse;
  logic [ADDR_W-1:0] busAddr;
  logic              busRead;
  logic              busWrite;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata = '0;
  logic              busRdValid = 1'b0;
  logic              busWaitReq = 1'b0;

  always #5 clk = ~clk;

  tcs_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .sideSel    (sideSel),
    .polySel    (polySel),
    .txInvSel   (txInvSel),
    .rxInvSel   (rxInvSel),
    .busy       (busy),
    .donePulse  (donePulse),
    .busAddr    (busAddr),
    .busRead    (busRead),
    .busWrite   (busWrite),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .busRdValid (busRdValid),
    .busWaitReq (busWaitReq)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    string             tag;
  } expItem_t;

  expItem_t          expQ[$];
  logic [DATA_W-1:0] mem [MEM_DEPTH];
  int                checkCnt = 0;
  int                failCnt = 0;
  logic              stallOn = 1'b0;
  logic [7:0]        lfsr = 8'h5A;
  int                rdCnt = 0;
  logic [ADDR_W-1:0] rdAddrQ = '0;
  logic [ADDR_W-1:0] lastRdAddr = '0;
  logic              readReturned = 1'b0;
  logic              newWait;

  task automatic chk(input bit ok, input string req,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
  endtask

  // slave model and scoreboard monitor, all on the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      busWaitReq = 1'b0;
      busRdValid = 1'b0;
      rdCnt      = 0;
    end else begin
      lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      newWait = stallOn & lfsr[0];
      busRdValid = 1'b0;
      if (rdCnt > 0) begin
        rdCnt--;
        if (rdCnt == 0) begin
          busRdValid   = 1'b1;
          busRdata     = mem[rdAddrQ[3:0]];
          readReturned = 1'b1;
        end
      end
      if (busRead && !newWait) begin
        rdCnt        = RD_LAT;
        rdAddrQ      = busAddr;
        lastRdAddr   = busAddr;
        readReturned = 1'b0;
      end
      if (busWrite && !newWait) begin
        // R2 R7: write must follow returned read data of the same address
        chk(readReturned && (lastRdAddr == busAddr), "R2 R7 read-before-write",
            DATA_W'(busAddr), DATA_W'(lastRdAddr));
        if (expQ.size() == 0) begin
          chk(1'b0, "R8 unexpected write", DATA_W'(busAddr), '0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(busAddr == e.addr, {e.tag, " address"}, DATA_W'(busAddr), DATA_W'(e.addr));
          chk(busWdata == e.data, {e.tag, " data"}, busWdata, e.data);
        end
        mem[busAddr[3:0]] = busWdata;
        readReturned = 1'b0;
      end
      busWaitReq = newWait;
    end
  end

  task automatic push(input int a, input logic [DATA_W-1:0] d, input string tag);
    expItem_t e;
    e.addr = ADDR_W'(a);
    e.data = d;
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  task automatic fillMem(input logic [DATA_W-1:0] base, input logic [DATA_W-1:0] step);
    for (int i = 0; i < MEM_DEPTH; i++) mem[i] = base ^ (step * DATA_W'(i));
  endtask

  // driver: compute expected writes, then launch a pass
  task automatic runSeq(input logic [1:0] side, input logic [1:0] poly,
                        input logic txi, input logic rxi, input bit disturb);
    logic [DATA_W-1:0] v;
    logic [3:0]        hot;
    hot = 4'b0001 << poly;
    if (side[0]) begin
      v = mem[6]; v[2:0] = 3'b100; v[3] = 1'b0; v[7:6] = 2'b01;
      push(6, v, "R2 R3 reg6");
      v = mem[7]; v[2] = txi; v[5] = hot[0]; v[6] = hot[1]; v[7] = hot[2];
      push(7, v, "R3 R4 reg7");
      v = mem[8]; v[4] = hot[3];
      push(8, v, "R3 R4 reg8");
    end
    if (side[1]) begin
      v = mem[10]; v[4] = rxi; v[7] = 1'b1;
      push(10, v, "R5 R6 regA");
    end
    @(negedge clk);
    sideSel = side; polySel = poly; txInvSel = txi; rxInvSel = rxi;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", DATA_W'(busy), 1);
    if (disturb) begin
      // R9: new settings mid-pass; R8: second start while busy
      sideSel = 2'b11; polySel = ~poly; txInvSel = ~txi; rxInvSel = ~rxi;
      @(negedge clk);
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    while (!donePulse) @(negedge clk);
    chk(busy == 1'b0, "R8 busy low with done", DATA_W'(busy), 0);
    chk(expQ.size() == 0, "R6 R9 all expected writes seen", DATA_W'(expQ.size()), 0);
    @(negedge clk);
    chk(donePulse == 1'b0, "R8 done one cycle", DATA_W'(donePulse), 0);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R8 no restart after done", DATA_W'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    fillMem(32'hA5C3_1E69, 32'h0123_4567);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0,      "R1 busy", DATA_W'(busy), 0);
    chk(donePulse == 1'b0, "R1 done", DATA_W'(donePulse), 0);
    chk(!busRead && !busWrite, "R1 bus idle", DATA_W'({busRead, busWrite}), 0);

    runSeq(2'b01, 2'd0, 1'b0, 1'b0, 1'b0);
    runSeq(2'b10, 2'd1, 1'b1, 1'b1, 1'b0);

    stallOn = 1'b1;
    fillMem('1, '0);
    runSeq(2'b11, 2'd1, 1'b1, 1'b0, 1'b0);

    fillMem('0, '0);
    runSeq(2'b11, 2'd2, 1'b0, 1'b1, 1'b1);

    runSeq(2'b11, 2'd3, 1'b1, 1'b1, 1'b0);

    // R6: start with no side selected does nothing
    @(negedge clk);
    sideSel = 2'b00; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int i = 0; i < 10; i++) begin
      chk(busy == 1'b0 && !busRead, "R6 empty select ignored", DATA_W'({busy, busRead}), 0);
      @(negedge clk);
    end

    fillMem(32'h3C5A_96F0, 32'h1111_0F0F);
    runSeq(2'b01, 2'd3, 1'b0, 1'b0, 1'b1);
    runSeq(2'b11, 2'd0, 1'b1, 1'b0, 1'b0);

    summary();
    $finish;
  end

endmodule